// File: doc/BRIEF.md
# Receive Self-Test Character Checker

This block sits behind a receive decoder. It checks each decoded character against a self-test pattern that it generates itself. A 9-bit maximal-length LFSR produces the pattern, which is 511 characters long. Most positions carry a data byte. Every 64th position carries a command (special) character, and position 0 is the start character that marks the beginning of a pass.

While the self-test is enabled, every accepted character produces one 3-bit status code. The codes are:

| Code | Meaning |
|------|---------|
| 000 | Data character matched |
| 001 | Command character matched |
| 010 | Last character of the pattern matched (the pass ended cleanly) |
| 110 | Mismatch |
| 111 | No comparison was made: still hunting for the start character, or the receive PLL is out of lock |

The block also shows the expected next character and keeps two sticky summary flags, one for a good pass and one for an error.

Characters arrive on a valid/ready input stream. The block never applies back-pressure: `in_ready` stays high, and a character is taken on every clock edge where `in_valid` is high. The status output is a registered one-cycle pulse, `st_valid`, with no ready signal. A consumer must take it in the cycle it appears. The enable, lock and summary pins are plain levels.

Top module: `rx_bist_monitor`

## Requirements
- R1: After reset, `st_valid`, `bist_pass` and `bist_fail` are low, and the expected character is the start character (`exp_data`=0xFF, `exp_special`=1).
- R2: The expected byte at pattern position p is bits [7:0] of LFSR state S_p. The states follow S_0=0x1FF and S_{p+1}={S_p[7:0], S_p[8]^S_p[4]}. Positions run from 0 to 510 and then repeat. `exp_special` is 1 exactly when p mod 64 = 0.
- R3: While hunting, with the test enabled and the PLL in lock, any character other than the start character (0xFF with the special flag set) reports 111. The start character reports 001, and comparison then continues at position 1.
- R4: While comparing, a match at a data position reports 000, and a match at a command position reports 001.
- R5: A match at position 510 reports 010. Comparison then continues at position 0 without a new hunt.
- R6: While comparing, a character whose byte or special flag differs from the expected one reports 110. The block then hunts for the start character again.
- R7: While `pll_lock` is low, every accepted character reports 111. Once lock returns, the block hunts for the start character.
- R8: While `bist_en` is low, no status is produced, and on the next clock the expected character returns to the start character.
- R9: `st_valid` is high for exactly the cycle after each edge that accepts a character while `bist_en` is high, and is low otherwise.
- R10: `bist_pass` rises together with a 010 status, and `bist_fail` rises together with a 110 status. Both stay set until `bist_en` is low at a clock edge.
- R11: `in_ready` is high whenever the block is out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Self-test enable (level) |
| pll_lock | input | 1 | Receive PLL lock indicator (level) |
| in_valid | input | 1 | Decoded character present |
| in_ready | output | 1 | Always high; the block never back-pressures |
| in_data | input | 8 | Decoded character byte |
| in_special | input | 1 | Character is a command (special) character |
| st_valid | output | 1 | Status code valid for this cycle |
| st_code | output | 3 | Per-character status code |
| exp_data | output | 8 | Expected next byte |
| exp_special | output | 1 | Expected next character is a command |
| bist_pass | output | 1 | Sticky: a full pattern pass ended cleanly |
| bist_fail | output | 1 | Sticky: a mismatch was seen |

## Verification
The assertions assume that `bist_en` and `pll_lock` are levels sampled on the clock edge like any other input. They also assume that a character accepted in a cycle is compared against the expected character shown in that same cycle. The bench meets both assumptions by changing every input only on the falling edge and by sending each character in a single-cycle `in_valid` pulse. It then walks the entire 511-position pattern, together with its wrap, and drives the mismatch, flag-mismatch, lock-loss and disable cases from known positions.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

  typedef enum logic [2:0] {
    ST_DATA_OK  = 3'b000,
    ST_CMD_OK   = 3'b001,
    ST_LAST_OK  = 3'b010,
    ST_MISMATCH = 3'b110,
    ST_NOSYNC   = 3'b111
  } bist_code_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HUNT,
    PH_CHECK,
    PH_NOLOCK
  } bist_phase_e;

endpackage

// File: rtl/rx_bist_patgen.sv
module rx_bist_patgen #(
  parameter int          LFSR_W    = 9,
  parameter int          TAP_HI    = 8,
  parameter int          TAP_LO    = 4,
  parameter logic [8:0]  SEED      = 9'h1FF,
  parameter int          CMD_EVERY = 64,
  parameter int          DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              rewind,
  output logic [DATA_W-1:0] exp_data,
  output logic              exp_cmd,
  output logic              exp_last
);
  localparam int POS_W   = LFSR_W;
  localparam int PAT_LEN = (1 << LFSR_W) - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAT_LEN - 1);
  localparam logic [LFSR_W-1:0] SEED_V  = LFSR_W'(SEED);

  logic [LFSR_W-1:0] lfsr_q;
  logic [POS_W-1:0]  pos_q;
  logic [LFSR_W-1:0] lfsr_step;

  assign lfsr_step = {lfsr_q[LFSR_W-2:0], lfsr_q[TAP_HI] ^ lfsr_q[TAP_LO]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED_V;
      pos_q  <= '0;
    end else if (rewind) begin
      lfsr_q <= SEED_V;
      pos_q  <= '0;
    end else if (advance) begin
      if (pos_q == LAST_POS) begin
        lfsr_q <= SEED_V;
        pos_q  <= '0;
      end else begin
        lfsr_q <= lfsr_step;
        pos_q  <= pos_q + 1'b1;
      end
    end
  end

  assign exp_data = lfsr_q[DATA_W-1:0];
  assign exp_last = (pos_q == LAST_POS);

  generate
    if ((CMD_EVERY & (CMD_EVERY - 1)) == 0) begin : g_cmd_mask
      localparam int SH = $clog2(CMD_EVERY);
      assign exp_cmd = (pos_q[SH-1:0] == '0);
    end else begin : g_cmd_mod
      assign exp_cmd = ((pos_q % POS_W'(CMD_EVERY)) == '0);
    end
  endgenerate

endmodule

// File: rtl/rx_bist_cmpfsm.sv
module rx_bist_cmpfsm
  import rx_bist_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              pll_lock,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_special,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              exp_cmd,
  input  logic              exp_last,
  output logic              advance,
  output logic              rewind,
  output logic              code_vld_nx,
  output bist_code_e        code_nx,
  output logic              st_valid,
  output logic [2:0]        st_code
);
  bist_phase_e ph_q, ph_nx;
  bist_code_e  code_q;
  logic        vld_q;
  logic        match;

  assign match = (in_data == exp_data) && (in_special == exp_cmd);

  always_comb begin
    ph_nx       = ph_q;
    advance     = 1'b0;
    rewind      = 1'b0;
    code_vld_nx = 1'b0;
    code_nx     = ST_NOSYNC;
    if (!bist_en) begin
      ph_nx  = PH_IDLE;
      rewind = 1'b1;
    end else if (!pll_lock) begin
      ph_nx       = PH_NOLOCK;
      rewind      = 1'b1;
      code_vld_nx = accept;
    end else if (ph_q == PH_CHECK) begin
      if (accept) begin
        code_vld_nx = 1'b1;
        if (match) begin
          advance = 1'b1;
          if (exp_last)     code_nx = ST_LAST_OK;
          else if (exp_cmd) code_nx = ST_CMD_OK;
          else              code_nx = ST_DATA_OK;
        end else begin
          rewind  = 1'b1;
          ph_nx   = PH_HUNT;
          code_nx = ST_MISMATCH;
        end
      end
    end else begin
      ph_nx = PH_HUNT;
      if (accept) begin
        code_vld_nx = 1'b1;
        if (match) begin
          advance = 1'b1;
          ph_nx   = PH_CHECK;
          code_nx = ST_CMD_OK;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      vld_q  <= 1'b0;
      code_q <= ST_NOSYNC;
    end else begin
      ph_q  <= ph_nx;
      vld_q <= code_vld_nx;
      if (code_vld_nx) code_q <= code_nx;
    end
  end

  assign st_valid = vld_q;
  assign st_code  = code_q;

endmodule

// File: rtl/rx_bist_summary.sv
module rx_bist_summary
  import rx_bist_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bist_en,
  input  logic       code_vld_nx,
  input  bist_code_e code_nx,
  output logic       bist_pass,
  output logic       bist_fail
);
  logic pass_q, fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (!bist_en) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (code_vld_nx) begin
      if (code_nx == ST_LAST_OK)  pass_q <= 1'b1;
      if (code_nx == ST_MISMATCH) fail_q <= 1'b1;
    end
  end

  assign bist_pass = pass_q;
  assign bist_fail = fail_q;

endmodule

// File: rtl/rx_bist_monitor.sv
module rx_bist_monitor
  import rx_bist_pkg::*;
#(
  parameter int         LFSR_W    = 9,
  parameter int         TAP_HI    = 8,
  parameter int         TAP_LO    = 4,
  parameter logic [8:0] SEED      = 9'h1FF,
  parameter int         CMD_EVERY = 64,
  parameter int         DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              pll_lock,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_special,
  output logic              st_valid,
  output logic [2:0]        st_code,
  output logic [DATA_W-1:0] exp_data,
  output logic              exp_special,
  output logic              bist_pass,
  output logic              bist_fail
);
  logic       accept, advance, rewind, exp_last, code_vld_nx;
  bist_code_e code_nx;

  assign in_ready = 1'b1;
  assign accept   = in_valid;

  rx_bist_patgen #(
    .LFSR_W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
    .SEED(SEED), .CMD_EVERY(CMD_EVERY), .DATA_W(DATA_W)
  ) u_patgen (
    .clk(clk), .rst_n(rst_n), .advance(advance), .rewind(rewind),
    .exp_data(exp_data), .exp_cmd(exp_special), .exp_last(exp_last)
  );

  rx_bist_cmpfsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .pll_lock(pll_lock),
    .accept(accept), .in_data(in_data), .in_special(in_special),
    .exp_data(exp_data), .exp_cmd(exp_special), .exp_last(exp_last),
    .advance(advance), .rewind(rewind), .code_vld_nx(code_vld_nx),
    .code_nx(code_nx), .st_valid(st_valid), .st_code(st_code)
  );

  rx_bist_summary u_summary (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en),
    .code_vld_nx(code_vld_nx), .code_nx(code_nx),
    .bist_pass(bist_pass), .bist_fail(bist_fail)
  );

endmodule

// File: rtl/rx_bist_monitor_sva.sv
module rx_bist_monitor_sva #(
  parameter logic [8:0] SEED   = 9'h1FF,
  parameter int         DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bist_en,
  input logic              pll_lock,
  input logic              in_valid,
  input logic              st_valid,
  input logic [2:0]        st_code,
  input logic [DATA_W-1:0] exp_data,
  input logic              exp_special,
  input logic              bist_pass,
  input logic              bist_fail
);
  localparam logic [DATA_W-1:0] START = SEED[DATA_W-1:0];

  assert_status_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bist_en) |=> st_valid);
  assert_no_spurious_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && bist_en) |=> !st_valid);
  assert_nolock_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bist_en && !pll_lock) |=> (st_valid && st_code == 3'b111));
  assert_disable_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> (exp_data == START && exp_special));
  assert_mismatch_rehunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_code == 3'b110) |-> (exp_data == START && exp_special && bist_fail));
  assert_last_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_code == 3'b010) |-> (exp_data == START && exp_special && bist_pass));
  assert_summary_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> (!bist_pass && !bist_fail));
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_fail && bist_en) |=> bist_fail);

endmodule

bind rx_bist_monitor rx_bist_monitor_sva #(.SEED(SEED), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .pll_lock(pll_lock),
  .in_valid(in_valid), .st_valid(st_valid), .st_code(st_code),
  .exp_data(exp_data), .exp_special(exp_special),
  .bist_pass(bist_pass), .bist_fail(bist_fail)
);

// File: tb/rx_bist_monitor_tb.sv
module rx_bist_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_en = 1'b0, pll_lock = 1'b1, in_valid = 1'b0, in_special = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, st_valid, exp_special, bist_pass, bist_fail;
  logic [2:0] st_code;
  logic [7:0] exp_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] pb [0:510];
  bit         pk [0:510];

  always #4 clk = ~clk;

  rx_bist_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .pll_lock(pll_lock),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_special(in_special), .st_valid(st_valid), .st_code(st_code),
    .exp_data(exp_data), .exp_special(exp_special),
    .bist_pass(bist_pass), .bist_fail(bist_fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic k);
    in_data = d; in_special = k; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_code(input logic [7:0] d, input logic k, input logic [2:0] c, input string req);
    send(d, k);
    chk(st_valid && st_code == c, req, {st_valid, st_code}, {1'b1, c});
  endtask

  function automatic logic [2:0] code_for(input int p);
    if (p == 510) return 3'b010;
    return pk[p] ? 3'b001 : 3'b000;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] s;
    s = 9'h1FF;
    for (int p = 0; p < 511; p++) begin
      pb[p] = s[7:0];
      pk[p] = (p % 64) == 0;
      s = {s[7:0], s[8] ^ s[4]};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!st_valid && !bist_pass && !bist_fail, "R1", {st_valid, bist_pass, bist_fail}, 0);
    chk(exp_data == 8'hFF && exp_special, "R1", {exp_special, exp_data}, 9'h1FF);
    chk(in_ready, "R11", in_ready, 1);

    bist_en = 1'b1;
    @(negedge clk);
    // R3 hunting rejects non-start characters
    send_code(8'h12, 1'b0, 3'b111, "R3");
    send_code(8'hFF, 1'b0, 3'b111, "R3");
    send_code(8'hBC, 1'b1, 3'b111, "R3");
    send_code(8'hFF, 1'b1, 3'b001, "R3");
    // R9 no status on idle cycle
    @(negedge clk);
    chk(!st_valid, "R9", st_valid, 0);

    // full pass, R2 R4 R5
    for (int p = 1; p < 511; p++) begin
      chk(exp_data == pb[p] && exp_special == pk[p], "R2", {exp_special, exp_data}, {pk[p], pb[p]});
      send_code(pb[p], pk[p], code_for(p), p == 510 ? "R5" : "R4");
    end
    chk(bist_pass && !bist_fail, "R10", {bist_pass, bist_fail}, 2'b10);
    // R5 wrap continues at position 0 without a hunt
    for (int p = 0; p < 11; p++)
      send_code(pb[p], pk[p], code_for(p), "R5");

    // R6 byte mismatch then re-hunt
    send_code(pb[11] ^ 8'h01, pk[11], 3'b110, "R6");
    chk(bist_fail && bist_pass, "R10", {bist_pass, bist_fail}, 2'b11);
    chk(exp_data == 8'hFF && exp_special, "R6", {exp_special, exp_data}, 9'h1FF);
    send_code(pb[12], pk[12], 3'b111, "R6");
    // R6 special-flag mismatch
    send_code(8'hFF, 1'b1, 3'b001, "R3");
    send_code(pb[1], 1'b1, 3'b110, "R6");

    // R7 lock loss
    send_code(8'hFF, 1'b1, 3'b001, "R3");
    send_code(pb[1], pk[1], 3'b000, "R4");
    pll_lock = 1'b0;
    send_code(pb[2], pk[2], 3'b111, "R7");
    send_code(8'hFF, 1'b1, 3'b111, "R7");
    pll_lock = 1'b1;
    @(negedge clk);
    send_code(pb[2], pk[2], 3'b111, "R7");
    send_code(8'hFF, 1'b1, 3'b001, "R7");
    send_code(pb[1], pk[1], 3'b000, "R7");

    // R8 disable
    bist_en = 1'b0;
    send(pb[2], pk[2]);
    chk(!st_valid, "R8", st_valid, 0);
    chk(exp_data == 8'hFF && exp_special, "R8", {exp_special, exp_data}, 9'h1FF);
    chk(!bist_pass && !bist_fail, "R10", {bist_pass, bist_fail}, 0);
    chk(in_ready, "R11", in_ready, 1);
    bist_en = 1'b1;
    @(negedge clk);
    send_code(pb[1], pk[1], 3'b111, "R8");
    send_code(8'hFF, 1'b1, 3'b001, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule